// File: doc/BRIEF.md
# Self-Checking Duplicated One-Hot State Machine

This block is a small control machine whose state register and next-state logic exist twice. Each copy holds the state one-hot. A copy is valid when exactly one of its bits is set. Two independent selector sets look at both copies and choose which copy's register bits each machine's next-state logic sees. As a result, an upset in one copy's register is replaced by the other copy's value within the same cycle, and both copies hold the same code again after the next edge. The output decoder is fed from selector set 0.

The example transition rule is a modulo-N step counter with a clear. Input bit 0 (`step`) moves state k to state k+1, wrapping from N-1 to 0. Input bit 1 (`clear`) sends the machine to state 0 and takes priority over `step`. With neither bit set, the state holds. Two injection vectors flip chosen register bits of either copy as the bits are captured, so a bench can model upsets. An error flag is raised when the two copies cannot be reconciled.

Top module: `dfsm_dup_onehot`

## Requirements
- R1: While `rst` is high, both copies load the one-hot code of state 0 at each clock edge. After that edge, `state_idx` is 0, `at_last` is 0 and `err` is 0.
- R2: At a clock edge, `ctrl_in` bit 1 (`clear`) moves the machine to state 0, whatever the value of bit 0. If bit 1 is low and bit 0 (`step`) is high, state k moves to state (k+1) mod N. If both bits are low, the state holds.
- R3: `state_idx` gives the binary index of the lowest set bit of selector set 0. It is 0 when no bit is set. `at_last` is high exactly when bit N-1 of that selection is set.
- R4: Bit i of `inj_a` or `inj_b`, high at a clock edge, inverts bit i of the value captured into copy 0 or copy 1. All-zero injection vectors have no effect.
- R5: A single inverted bit in either copy's register does not change `state_idx`, `at_last` or the next state, and leaves `err` low. After the following edge, both copies hold the same valid code.
- R6: When neither copy is valid, `err` is high and copy 0's raw bits are forwarded. From the all-zero code, `clear` restores state 0 and clears `err`.
- R7: When both copies are valid but differ, `err` is high and copy 0 is forwarded to both machines. After the next edge, both copies hold the successor of copy 0's state and `err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_in | input | 2 | bit 0 step, bit 1 clear |
| inj_a | input | N_STATES | Bit-flip injection mask for copy 0 |
| inj_b | input | N_STATES | Bit-flip injection mask for copy 1 |
| state_idx | output | $clog2(N_STATES) | Binary index of the selected state |
| at_last | output | 1 | High in state N_STATES-1 |
| err | output | 1 | Copies invalid or in conflict |

## Verification
The assertion that the copies agree after every edge assumes that both injection masks were zero at the previous edge and that `err` was low. The assertions that relate validity to `err` assume that the two copies differ only through the injection ports. The bench keeps to these conditions: it drives an injection mask for exactly one edge and then clears it. It also runs every fault scenario from a known state, which the port-level model tracks. Double faults are applied only in the R6 and R7 scenarios, where a wrong state or a raised flag is the expected result.

// File: rtl/dfsm_pkg.sv
package dfsm_pkg;
   localparam int CTRL_W    = 2;
   localparam int STEP_BIT  = 0;
   localparam int CLEAR_BIT = 1;
endpackage

// File: rtl/dfsm_next.sv
module dfsm_next #(
   parameter int N_STATES = 5
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [N_STATES-1:0]        cur,
   input  logic [dfsm_pkg::CTRL_W-1:0] ctrl,
   output logic [N_STATES-1:0]        nxt
);
   logic step, clr;
   assign step = ctrl[dfsm_pkg::STEP_BIT];
   assign clr  = ctrl[dfsm_pkg::CLEAR_BIT];

   for (genvar i = 0; i < N_STATES; i++) begin : g_bit
      localparam int PREV = (i == 0) ? N_STATES - 1 : i - 1;
      if (i == 0) begin : g_home
         assign nxt[i] = clr | (step ? cur[PREV] : cur[i]);
      end else begin : g_other
         assign nxt[i] = !clr & (step ? cur[PREV] : cur[i]);
      end
   end

   // R2
   next_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot(cur) |-> $onehot(nxt));
endmodule

// File: rtl/dfsm_select.sv
module dfsm_select #(
   parameter int N_STATES = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [N_STATES-1:0] q0,
   input  logic [N_STATES-1:0] q1,
   output logic [N_STATES-1:0] sel,
   output logic                conflict
);
   logic ok0, ok1;
   assign ok0 = $onehot(q0);
   assign ok1 = $onehot(q1);

   always_comb begin
      if (ok0)      sel = q0;
      else if (ok1) sel = q1;
      else          sel = q0;
   end

   assign conflict = (!ok0 && !ok1) || (ok0 && ok1 && (q0 != q1));

   // R5
   sel_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (ok0 || ok1) |-> $onehot(sel));
endmodule

// File: rtl/dfsm_out.sv
module dfsm_out #(
   parameter int N_STATES = 5,
   localparam int IDX_W = $clog2(N_STATES)
) (
   input  logic [N_STATES-1:0] sel,
   output logic [IDX_W-1:0]    idx,
   output logic                last
);
   always_comb begin
      idx = '0;
      for (int i = N_STATES - 1; i >= 0; i--)
         if (sel[i]) idx = IDX_W'(i);
   end
   assign last = sel[N_STATES-1];
endmodule

// File: rtl/dfsm_dup_onehot.sv
module dfsm_dup_onehot #(
   parameter int N_STATES = 5,
   localparam int IDX_W = $clog2(N_STATES)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [dfsm_pkg::CTRL_W-1:0] ctrl_in,
   input  logic [N_STATES-1:0]         inj_a,
   input  logic [N_STATES-1:0]         inj_b,
   output logic [IDX_W-1:0]            state_idx,
   output logic                        at_last,
   output logic                        err
);
   localparam logic [N_STATES-1:0] HOME_OH = N_STATES'(1);

   if (N_STATES < 2) begin : g_bad_n
      $error("dfsm_dup_onehot: N_STATES must be at least 2");
   end

   logic [1:0][N_STATES-1:0] q;
   logic [1:0][N_STATES-1:0] sel;
   logic [1:0][N_STATES-1:0] nxt;
   logic [1:0][N_STATES-1:0] inj;
   logic [1:0]               conflict;

   assign inj[0] = inj_a;
   assign inj[1] = inj_b;

   for (genvar c = 0; c < 2; c++) begin : g_copy
      dfsm_select #(.N_STATES(N_STATES)) u_sel (
         .clk(clk), .rst(rst), .q0(q[0]), .q1(q[1]),
         .sel(sel[c]), .conflict(conflict[c]));

      dfsm_next #(.N_STATES(N_STATES)) u_next (
         .clk(clk), .rst(rst), .cur(sel[c]), .ctrl(ctrl_in), .nxt(nxt[c]));

      always_ff @(posedge clk) begin
         if (rst) q[c] <= HOME_OH;
         else     q[c] <= nxt[c] ^ inj[c];
      end
   end

   dfsm_out #(.N_STATES(N_STATES)) u_out (
      .sel(sel[0]), .idx(state_idx), .last(at_last));

   assign err = |conflict;

   // R1
   reset_home_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (state_idx == '0 && !err));

   // R5
   single_fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ($onehot(q[0]) != $onehot(q[1])) |-> !err);

   // R5
   copies_rejoin_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(inj_a) == '0 && $past(inj_b) == '0 && !$past(err)) |-> (q[0] == q[1]));

   // R7
   conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
      ($onehot(q[0]) && $onehot(q[1]) && q[0] != q[1]) |-> err);

   // R6
   both_bad_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (!$onehot(q[0]) && !$onehot(q[1])) |-> err);
endmodule

// File: tb/dfsm_dup_onehot_test.sv
module dfsm_dup_onehot_test;
   localparam int N = 5;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0]   ctrl_in = '0;
   logic [N-1:0] inj_a = '0;
   logic [N-1:0] inj_b = '0;
   logic [IW-1:0] state_idx;
   logic at_last, err;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_k = 0;

   always #10 clk = ~clk;

   dfsm_dup_onehot #(.N_STATES(N)) uut (
      .clk(clk), .rst(rst), .ctrl_in(ctrl_in), .inj_a(inj_a), .inj_b(inj_b),
      .state_idx(state_idx), .at_last(at_last), .err(err));

   task automatic check(input string tag, input int got, input int expv);
      n_cmp++;
      if (got != expv) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, expv);
      end
   endtask

   task automatic check_state(input string tag, input int k, input int e);
      check({tag, " idx"}, int'(state_idx), k);
      check({tag, " last"}, int'(at_last), (k == N - 1) ? 1 : 0);
      check({tag, " err"}, int'(err), e);
   endtask

   // one edge with given inputs; outputs sampled at the following negedge
   task automatic cycle(input logic [1:0] c, input logic [N-1:0] ia, input logic [N-1:0] ib);
      ctrl_in = c; inj_a = ia; inj_b = ib;
      @(negedge clk);
      inj_a = '0; inj_b = '0;
   endtask

   task automatic go_home();
      cycle(2'b10, '0, '0);
      exp_k = 0;
   endtask

   task automatic t_reset();
      check_state("R1 reset", 0, 0);
   endtask

   task automatic t_transitions();
      go_home();
      for (int s = 0; s < N + 2; s++) begin
         cycle(2'b01, '0, '0);
         exp_k = (exp_k + 1) % N;
         check_state("R2 R3 step", exp_k, 0);
      end
      cycle(2'b00, '0, '0);
      check_state("R2 hold", exp_k, 0);
      cycle(2'b11, '0, '0);
      exp_k = 0;
      check_state("R2 clear priority", 0, 0);
      cycle(2'b00, '0, '0);
      check_state("R4 zero mask", 0, 0);
   endtask

   task automatic t_single(input bit on_b);
      for (int b = 0; b < N; b++) begin
         logic [N-1:0] m;
         go_home();
         cycle(2'b01, '0, '0);
         exp_k = 1;
         m = N'(1) << b;
         exp_k = (exp_k + 1) % N;
         if (on_b) cycle(2'b01, '0, m);
         else      cycle(2'b01, m, '0);
         check_state(on_b ? "R5 copy1 flip" : "R5 copy0 flip", exp_k, 0);
         cycle(2'b01, '0, '0);
         exp_k = (exp_k + 1) % N;
         check_state("R4 R5 after flip", exp_k, 0);
         cycle(2'b00, '0, '0);
         check_state("R5 rejoined", exp_k, 0);
      end
   endtask

   task automatic t_both_bad();
      go_home();
      cycle(2'b01, '0, '0);
      cycle(2'b01, '0, '0);
      exp_k = 2;
      cycle(2'b00, N'(1) << 2, N'(1) << 2);
      check_state("R6 both invalid", 0, 1);
      cycle(2'b01, '0, '0);
      check_state("R6 stays empty", 0, 1);
      cycle(2'b10, '0, '0);
      check_state("R6 clear recovers", 0, 0);
      cycle(2'b01, '0, '0);
      check_state("R6 step after recover", 1, 0);
   endtask

   task automatic t_conflict();
      go_home();
      cycle(2'b01, '0, '0);
      exp_k = 1;
      cycle(2'b00, (N'(1) << 1) | (N'(1) << 3), '0);
      check_state("R7 conflict copy0 wins", 3, 1);
      cycle(2'b01, '0, '0);
      check_state("R7 follows copy0", 4, 0);
      cycle(2'b01, '0, '0);
      check_state("R7 wraps", 0, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_transitions();
      t_single(1'b0);
      t_single(1'b1);
      t_both_bad();
      t_conflict();
      summary();
   end

   initial begin
      #(20 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
   end
endmodule